// File: doc/BRIEF.md
# Serial Frame Receiver with CRC-8 Validation

This block is the serial slave front end of a device that holds many registers. A host frames each transfer by pulling the active-low select line `sync_n` low. It then clocks bits in on `sclk`, and the block samples `sdi` on each falling edge, most significant bit first. When `sync_n` returns high, the block judges the frame by its bit count.

A 24-bit frame is an 8-bit register address followed by 16 data bits, and it is committed without further checks. A 32-bit frame carries the same 24 bits plus an 8-bit CRC as a trailer. It is committed only when the CRC agrees; otherwise the block raises a one-cycle packet-error pulse, which the status logic elsewhere turns into a status bit and a fault indication. Frames of any other length are dropped silently.

While the status-readback control input is set, the block returns the 16-bit status word on `sdo` during every frame. This lets the host watch for faults on each write. `sclk`, `sync_n` and `sdi` are asynchronous to `clk` and pass through a synchronizer, so `clk` must run several times faster than `sclk`.

Top module: `spi_frame_rx`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `wr_stb`, `pec_err` and `sdo` are 0.
- R2: A bit is taken from `sdi` only on a falling edge of `sclk` while `sync_n` is low, MSB first. A frame of exactly 24 bits gives one `wr_stb` pulse after `sync_n` rises, with `wr_addr` = the first 8 bits and `wr_data` = the next 16 bits.
- R3: In a frame of exactly 32 bits, bits 1–8 are the address, bits 9–24 are the data and bits 25–32 are a CRC. This CRC uses generator x^8+x^2+x+1 (0x07) and initial value 0x00, and it is computed MSB first over the 24 address and data bits. When the received CRC equals the computed one, the block gives one `wr_stb` pulse with that address and data.
- R4: A 32-bit frame whose CRC does not match gives no `wr_stb` and exactly one `pec_err` pulse.
- R5: A frame of any bit count other than 24 or 32 (including 0 and more than 32) gives neither `wr_stb` nor `pec_err`.
- R6: `wr_stb` and `pec_err` each last one `clk` cycle and are never high together. Each is raised only in the cycle after the block leaves a frame.
- R7: `stat_rd_en` and `status_word` are captured when `sync_n` falls. If `stat_rd_en` was 1, `sdo` presents status bit 15 first, and each `sclk` falling edge advances `sdo` to the next lower bit. After 16 bits `sdo` is 0. Changes to `status_word` during the frame have no effect on that frame.
- R8: `sdo` is 0 whenever `sync_n` is high, and during a whole frame that began with `stat_rd_en` at 0. Status readback does not block writes: frames are judged the same way in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles low |
| sync_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| stat_rd_en | input | 1 | Status-readback mode control bit |
| status_word | input | 16 | Status word returned on sdo |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 16 | Register data of the write |
| pec_err | output | 1 | One-cycle CRC failure pulse |
| sdo | output | 1 | Serial data out |

## Verification
The assertions assume that `sync_n` changes are separated by several `clk` cycles. They also assume that no `sclk` falling edge coincides with a `sync_n` edge, so that exactly one verdict can follow each frame. The stimulus keeps every `sclk` phase at four `clk` cycles. It keeps `sclk` low and waits four cycles on both sides of each `sync_n` edge, and it leaves ten idle cycles between frames. Within those limits it randomizes frame length, address, data, CRC corruption, mode and status value.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  typedef enum logic [1:0] {
    VERD_DROP    = 2'd0,
    VERD_SHORT   = 2'd1,
    VERD_LONG_OK = 2'd2,
    VERD_LONG_BAD= 2'd3
  } verdict_e;

  // one serial step of an MSB-first CRC with zero init
  function automatic logic [7:0] crc8_step(input logic [7:0] cur,
                                           input logic       din,
                                           input logic [7:0] poly);
    logic fb;
    fb = cur[7] ^ din;
    return {cur[6:0], 1'b0} ^ (fb ? poly : 8'h00);
  endfunction

endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[s] <= RST_VAL;
        end else if (s == 0) begin
          chain[s] <= d_in;
        end else begin
          chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/spi_rx_crc.sv
module spi_rx_crc #(
  parameter int              CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q
);
  import spi_rx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc_q <= '0;
    end else if (bit_en) begin
      crc_q <= crc8_step(crc_q, bit_in, POLY);
    end
  end

endmodule

// File: rtl/spi_rx_sdo.sv
module spi_rx_sdo #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              mode,
  input  logic [STAT_W-1:0] status,
  input  logic              shift,
  input  logic              clear,
  output logic              sdo
);

  logic [STAT_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= mode ? status : '0;
    end else if (shift) begin
      sh_q <= {sh_q[STAT_W-2:0], 1'b0};
    end
  end

  assign sdo = sh_q[STAT_W-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 16,
  parameter int              CRC_W       = 8,
  parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07,
  parameter int              STAT_W      = 16,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdi,
  input  logic              stat_rd_en,
  input  logic [STAT_W-1:0] status_word,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pec_err,
  output logic              sdo
);
  import spi_rx_pkg::*;

  localparam int SHORT_LEN = ADDR_W + DATA_W;
  localparam int LONG_LEN  = SHORT_LEN + CRC_W;
  localparam int CNT_MAX   = LONG_LEN + 1;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  // synchronized pins: {sync_n, sclk, sdi}
  logic [2:0] pins_s;
  logic       sync_s, sclk_s, sdi_s;
  logic       sync_prev, sclk_prev;
  logic       sync_fall, sync_rise, bit_tick;
  logic       frame_active;
  logic [CNT_W-1:0]    bit_cnt;
  logic [LONG_LEN-1:0] shreg;
  logic [CRC_W-1:0]    crc_q;
  verdict_e            verdict;

  spi_rx_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({sync_n, sclk, sdi}),
    .d_out(pins_s)
  );

  assign sync_s = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_prev <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      sync_prev <= sync_s;
      sclk_prev <= sclk_s;
    end
  end

  assign sync_fall = sync_prev & ~sync_s;
  assign sync_rise = ~sync_prev & sync_s;
  assign bit_tick  = frame_active & sclk_prev & ~sclk_s & ~sync_s;

  // frame state, bit counter and data shift register
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_active <= 1'b0;
      bit_cnt      <= '0;
      shreg        <= '0;
    end else if (sync_fall) begin
      frame_active <= 1'b1;
      bit_cnt      <= '0;
      shreg        <= '0;
    end else if (sync_rise) begin
      frame_active <= 1'b0;
    end else if (bit_tick) begin
      shreg <= {shreg[LONG_LEN-2:0], sdi_s};
      if (bit_cnt != CNT_W'(CNT_MAX)) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  spi_rx_crc #(
    .CRC_W(CRC_W),
    .POLY (CRC_POLY)
  ) u_crc (
    .clk   (clk),
    .rst   (rst),
    .clear (sync_fall),
    .bit_en(bit_tick),
    .bit_in(sdi_s),
    .crc_q (crc_q)
  );

  spi_rx_sdo #(
    .STAT_W(STAT_W)
  ) u_sdo (
    .clk   (clk),
    .rst   (rst),
    .load  (sync_fall),
    .mode  (stat_rd_en),
    .status(status_word),
    .shift (bit_tick),
    .clear (sync_rise),
    .sdo   (sdo)
  );

  // frame verdict at the end of select
  always_comb begin
    if (bit_cnt == CNT_W'(SHORT_LEN)) begin
      verdict = VERD_SHORT;
    end else if (bit_cnt == CNT_W'(LONG_LEN)) begin
      verdict = (crc_q == '0) ? VERD_LONG_OK : VERD_LONG_BAD;
    end else begin
      verdict = VERD_DROP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      pec_err <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb  <= 1'b0;
      pec_err <= 1'b0;
      if (sync_rise && frame_active) begin
        unique case (verdict)
          VERD_SHORT: begin
            wr_stb  <= 1'b1;
            wr_addr <= shreg[SHORT_LEN-1 -: ADDR_W];
            wr_data <= shreg[DATA_W-1:0];
          end
          VERD_LONG_OK: begin
            wr_stb  <= 1'b1;
            wr_addr <= shreg[LONG_LEN-1 -: ADDR_W];
            wr_data <= shreg[CRC_W +: DATA_W];
          end
          VERD_LONG_BAD: pec_err <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk (
  input logic clk,
  input logic rst,
  input logic wr_stb,
  input logic pec_err,
  input logic sdo,
  input logic frame_active
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wr_stb && !pec_err && !sdo));

  assert_wr_after_frame_R2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (!frame_active && $past(frame_active)));

  assert_pec_after_frame_R4: assert property (@(posedge clk) disable iff (rst)
    pec_err |-> (!frame_active && $past(frame_active)));

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_pec_single_R6: assert property (@(posedge clk) disable iff (rst)
    pec_err |=> !pec_err);

  assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && pec_err));

  assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_active |-> !sdo);

endmodule

bind spi_frame_rx spi_frame_rx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_stb      (wr_stb),
  .pec_err     (pec_err),
  .sdo         (sdo),
  .frame_active(frame_active)
);

// File: tb/spi_frame_rx_tb.sv
module spi_frame_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        sync_n = 1'b1;
  logic        sdi = 1'b0;
  logic        stat_rd_en = 1'b0;
  logic [15:0] status_word = '0;
  logic        wr_stb, pec_err, sdo;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0;
  int fails  = 0;
  int n_wr   = 0;
  int n_pec  = 0;
  logic [7:0]  last_addr;
  logic [15:0] last_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_rx u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
    .stat_rd_en(stat_rd_en), .status_word(status_word),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .pec_err(pec_err), .sdo(sdo)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        n_wr++;
        last_addr = wr_addr;
        last_data = wr_data;
      end
      if (pec_err) n_pec++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      logic fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // v holds the frame right-aligned, sent MSB first over n bits
  task automatic run_frame(input logic [39:0] v, input int n,
                           input logic mode, input logic [15:0] st,
                           input string req);
    int wr0 = n_wr;
    int pec0 = n_pec;
    int sdo_bad = 0;
    logic exp_wr, exp_pec;
    logic [7:0]  ea;
    logic [15:0] ed;
    exp_wr = 1'b0; exp_pec = 1'b0; ea = '0; ed = '0;
    if (n == 24) begin
      exp_wr = 1'b1; ea = v[23:16]; ed = v[15:0];
    end else if (n == 32) begin
      if (ref_crc(v[31:8]) == v[7:0]) begin
        exp_wr = 1'b1; ea = v[31:24]; ed = v[23:8];
      end else begin
        exp_pec = 1'b1;
      end
    end
    @(negedge clk);
    stat_rd_en  = mode;
    status_word = st;
    sync_n = 1'b0;
    repeat (PH) @(negedge clk);
    status_word = ~st;                 // R7: must not affect this frame
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      sdi  = v[n-1-i];
      repeat (PH) @(negedge clk);
      if (sdo !== ((mode && i < 16) ? st[15-i] : 1'b0)) sdo_bad++;
      sclk = 1'b0;
      repeat (PH) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sdo === 1'b0, "R8", "sdo idle after frame", sdo, 0);
    check(sdo_bad == 0, mode ? "R7" : "R8", "sdo bit mismatches", sdo_bad, 0);
    check((n_wr - wr0) == int'(exp_wr), req, "write count", n_wr - wr0, exp_wr);
    check((n_pec - pec0) == int'(exp_pec), exp_pec ? "R4" : req, "pec count",
          n_pec - pec0, exp_pec);
    if (exp_wr) begin
      check(last_addr == ea, req, "address", last_addr, ea);
      check(last_data == ed, req, "data", last_data, ed);
    end
  endtask

  function automatic logic [39:0] good_long(input logic [23:0] d);
    return {8'h00, d, ref_crc(d)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(wr_stb === 1'b0 && pec_err === 1'b0 && sdo === 1'b0, "R1",
          "outputs in reset", {wr_stb, pec_err, sdo}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(wr_stb === 1'b0 && pec_err === 1'b0 && sdo === 1'b0, "R1",
          "outputs after reset", {wr_stb, pec_err, sdo}, 0);

    // directed corners
    run_frame({16'h0, 24'hA5_1234}, 24, 1'b0, 16'h0000, "R2");
    run_frame(good_long(24'h3C_BEEF), 32, 1'b0, 16'h0000, "R3");
    run_frame(good_long(24'h00_0000), 32, 1'b1, 16'h8001, "R3");
    run_frame(good_long(24'h7F_0F0F) ^ 40'h1, 32, 1'b0, 16'h0, "R4");
    run_frame(good_long(24'hFF_FFFF) ^ 40'h80, 32, 1'b1, 16'hC3A5, "R4");
    run_frame(40'h0, 0, 1'b0, 16'h0, "R5");
    run_frame({17'h0, 23'h12_3456}, 23, 1'b1, 16'hFFFF, "R5");
    run_frame({15'h0, 25'h1AB_CDEF}, 25, 1'b0, 16'h0, "R5");
    run_frame({9'h0, 31'h1234_5678}, 31, 1'b0, 16'h0, "R5");
    run_frame({7'h0, good_long(24'h11_2233)[31:0], 1'b0}, 33, 1'b0, 16'h0, "R5");
    run_frame({16'h0, 24'h01_8000}, 24, 1'b1, 16'h5A5A, "R8");
    run_frame({16'h0, 24'hFE_0001}, 24, 1'b0, 16'hFFFF, "R8");

    // constrained random mix
    for (int k = 0; k < 60; k++) begin
      logic [23:0] d = 24'($urandom);
      logic [15:0] st = 16'($urandom);
      logic mode = 1'($urandom);
      int sel = int'($urandom_range(0, 3));
      case (sel)
        0: run_frame({16'h0, d}, 24, mode, st, "R2");
        1: run_frame(good_long(d), 32, mode, st, "R3");
        2: run_frame(good_long(d) ^ 40'(1 << $urandom_range(0, 31)), 32, mode, st, "R4");
        default: begin
          int n = int'($urandom_range(1, 36));
          if (n == 24 || n == 32) n = n + 1;
          run_frame({8'($urandom), d, 8'($urandom)}, n, mode, st, "R5");
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule